// File: doc/BRIEF.md
# Fixed-Point Q-Format Arithmetic Unit

This unit adds, subtracts or multiplies two words held in a fixed-point Q format. The word width and the number of fraction bits are parameters. A per-operation input selects whether both operands and the result are read as two's-complement signed values or as unsigned values. With the defaults this gives a 32-bit word with 16 fraction bits, which is Q15.16 when signed and UQ16.16 when unsigned.

Addition and subtraction act directly on the integer representations. Multiplication first forms the exact product, whose integer and fraction widths are the sums of those of the two operands. It then brings the product back to the operand format by shifting right by the fraction width. The shift either truncates or rounds to nearest.

Each operation is checked against the range of the output word, and an overflow flag reports any result that does not fit. An optional saturate input then clamps the result to the nearest end of the range. Results are registered and appear one clock after the request.

Top module: `qfx_alu`

## Requirements
- R1: out_valid equals in_valid of the previous clock. result and ovf load only on a clock where in_valid is high and otherwise hold their values. A synchronous rst clears out_valid, result and ovf to 0.
- R2: The op encoding is 2'b00 for add and 2'b01 for subtract (a minus b). Either code with op[1] set (2'b10 or 2'b11) selects multiply.
- R3: Add and subtract produce the integer sum or difference of the two raw words, with no rescaling. round_en has no effect on them.
- R4: Multiply forms the exact product of the raw words and shifts it right by FRAC bits. With round_en low, the dropped bits are discarded, which rounds toward minus infinity.
- R5: With round_en high, multiply rounds to the nearest representable value. A tie rounds away from zero, so -0.5 LSB gives -1 LSB and +0.5 LSB gives +1 LSB.
- R6: With is_signed high, ovf is set when the exact result lies outside [-2^(W-1), 2^(W-1)-1] in raw units.
- R7: With is_signed low, ovf is set when the exact result lies outside [0, 2^W-1] in raw units. This includes a subtraction whose result would be negative.
- R8: With sat_en low, result is the low W bits of the exact (rounded) result, even when ovf is set.
- R9: With sat_en high and ovf set, result clamps to the range end on the side of the exact result. For signed words the ends are 0x7FFF_FFFF and 0x8000_0000. For unsigned words they are 0xFFFF_FFFF and 0.
- R10: is_signed selects how each operand's top bit is read. High reads it as a two's-complement sign. Low reads it as the most significant magnitude bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request |
| op | input | 2 | 00 add, 01 subtract, 1x multiply |
| is_signed | input | 1 | 1 signed two's complement, 0 unsigned |
| round_en | input | 1 | 1 round to nearest on multiply, 0 truncate |
| sat_en | input | 1 | Clamp the result on overflow |
| a | input | W | First operand |
| b | input | W | Second operand |
| out_valid | output | 1 | Result valid, one clock after in_valid |
| result | output | W | Registered result |
| ovf | output | 1 | Result did not fit the output range |

## Verification
The bench builds the unit with its default parameters: a 32-bit word with 16 fraction bits. Hand-worked operands therefore land on easy values, such as 0x8000 for one half and 0x10000 for one. These values reach the half-LSB rounding position and the sign-bit range check over the upper product bits. They also make it simple to pick products that differ only in whether the top bit is read as a sign. Directed operands are chosen to sit exactly on rounding ties, on the range ends, and on unsigned underflow, so that each flag and clamp decision can be seen at the ports.

// File: rtl/qfx_pkg.sv
package qfx_pkg;
  typedef enum logic [1:0] {
    QOP_ADD = 2'b00,
    QOP_SUB = 2'b01,
    QOP_MUL = 2'b10,
    QOP_MLX = 2'b11
  } qop_e;
endpackage

// File: rtl/qfx_addsub.sv
module qfx_addsub #(
  parameter int W = 32
) (
  input  logic             sg,
  input  logic             sub,
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  output logic [W+1:0]     wide
);
  localparam int AW = W + 2;

  logic signed [AW-1:0] ea;
  logic signed [AW-1:0] eb;

  // two guard bits: one for the carry, one for a true sign
  assign ea = {{2{sg & a[W-1]}}, a};
  assign eb = {{2{sg & b[W-1]}}, b};

  always_comb begin
    if (sub) wide = ea - eb;
    else     wide = ea + eb;
  end
endmodule

// File: rtl/qfx_mul.sv
module qfx_mul #(
  parameter int W    = 32,
  parameter int FRAC = 16
) (
  input  logic                    sg,
  input  logic                    rnd,
  input  logic [W-1:0]            a,
  input  logic [W-1:0]            b,
  output logic [2*W+1-FRAC:0]     scaled
);
  localparam int XW = W + 1;
  localparam int PW = 2 * XW;

  logic signed [XW-1:0] xa;
  logic signed [XW-1:0] xb;
  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] adj;

  assign xa   = {sg & a[W-1], a};
  assign xb   = {sg & b[W-1], b};
  assign prod = PW'(xa) * PW'(xb);

  generate
    if (FRAC > 0) begin : g_frac
      localparam logic [PW-1:0] HALF = PW'(1) << (FRAC - 1);
      logic [PW-1:0] bias;
      always_comb begin
        if (!rnd)              bias = '0;
        else if (prod[PW-1])   bias = HALF - PW'(1);  // ties away from zero
        else                   bias = HALF;
      end
      assign adj    = prod + bias;
      assign scaled = adj[PW-1:FRAC];
    end else begin : g_int
      assign adj    = prod;
      assign scaled = adj;
    end
  endgenerate
endmodule

// File: rtl/qfx_narrow.sv
module qfx_narrow #(
  parameter int W    = 32,
  parameter int IN_W = 50
) (
  input  logic              sg,
  input  logic              sat,
  input  logic [IN_W-1:0]   val,
  output logic [W-1:0]      res,
  output logic              ovf
);
  logic neg;
  logic hi_ones;
  logic hi_zero;
  logic top_zero;

  assign neg      = val[IN_W-1];
  assign hi_ones  = &val[IN_W-1:W-1];
  assign hi_zero  = ~|val[IN_W-1:W-1];
  assign top_zero = ~|val[IN_W-1:W];

  always_comb begin
    if (sg) ovf = !(hi_ones || hi_zero);
    else    ovf = !top_zero;

    if (ovf && sat) begin
      if (sg) res = neg ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
      else    res = neg ? '0 : '1;
    end else begin
      res = val[W-1:0];
    end
  end
endmodule

// File: rtl/qfx_alu.sv
module qfx_alu #(
  parameter int W    = 32,
  parameter int FRAC = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [1:0]    op,
  input  logic          is_signed,
  input  logic          round_en,
  input  logic          sat_en,
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  output logic          out_valid,
  output logic [W-1:0]  result,
  output logic          ovf
);
  import qfx_pkg::*;

  localparam int AW = W + 2;
  localparam int MW = 2 * W + 2 - FRAC;

  logic [AW-1:0] as_wide;
  logic [MW-1:0] mul_wide;
  logic [MW-1:0] sel_wide;
  logic [W-1:0]  nar_res;
  logic          nar_ovf;
  logic          is_mul;

  assign is_mul = (qop_e'(op) == QOP_MUL) || (qop_e'(op) == QOP_MLX);

  qfx_addsub #(.W(W)) u_addsub (
    .sg   (is_signed),
    .sub  (op[0]),
    .a    (a),
    .b    (b),
    .wide (as_wide)
  );

  qfx_mul #(.W(W), .FRAC(FRAC)) u_mul (
    .sg     (is_signed),
    .rnd    (round_en),
    .a      (a),
    .b      (b),
    .scaled (mul_wide)
  );

  assign sel_wide = is_mul ? mul_wide : {{(MW-AW){as_wide[AW-1]}}, as_wide};

  qfx_narrow #(.W(W), .IN_W(MW)) u_narrow (
    .sg  (is_signed),
    .sat (sat_en),
    .val (sel_wide),
    .res (nar_res),
    .ovf (nar_ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      ovf       <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= nar_res;
        ovf    <= nar_ovf;
      end
    end
  end
endmodule

// File: rtl/qfx_alu_chk.sv
module qfx_alu_chk #(
  parameter int W    = 32,
  parameter int FRAC = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [1:0]    op,
  input logic          is_signed,
  input logic          round_en,
  input logic          sat_en,
  input logic [W-1:0]  a,
  input logic [W-1:0]  b,
  input logic          out_valid,
  input logic [W-1:0]  result,
  input logic          ovf
);
  logic [W:0] usum;
  assign usum = {1'b0, a} + {1'b0, b};

  // R1: one-cycle valid latency
  p_valid_lat_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(result) && $stable(ovf)));

  // R3 / R8: unsigned add without saturation wraps to the low bits
  p_add_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'b00 && !is_signed && !sat_en) |=> result == $past(usum[W-1:0]));

  // R7: unsigned add overflow equals the carry out
  p_add_ovf_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'b00 && !is_signed) |=> ovf == $past(usum[W]));

  // R4: a zero operand gives a zero product with no overflow
  p_mul_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op[1] && (a == '0 || b == '0)) |=> (result == '0 && !ovf));

  // R9: a saturated overflow lands on a range end
  p_sat_end_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sat_en) |=> (!ovf || result == '0 || result == '1 ||
      result == {1'b1, {(W-1){1'b0}}} || result == {1'b0, {(W-1){1'b1}}}));
endmodule

bind qfx_alu qfx_alu_chk #(.W(W), .FRAC(FRAC)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .is_signed(is_signed),
  .round_en(round_en), .sat_en(sat_en), .a(a), .b(b),
  .out_valid(out_valid), .result(result), .ovf(ovf)
);

// File: tb/qfx_alu_bench.sv
module qfx_alu_bench;
  localparam int W    = 32;
  localparam int FRAC = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [1:0]    op = 2'b00;
  logic          is_signed = 1'b0;
  logic          round_en = 1'b0;
  logic          sat_en = 1'b0;
  logic [W-1:0]  a = '0;
  logic [W-1:0]  b = '0;
  logic          out_valid;
  logic [W-1:0]  result;
  logic          ovf;

  int n_run  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit done   = 0;

  qfx_alu #(.W(W), .FRAC(FRAC)) u_qfx_alu (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .is_signed(is_signed),
    .round_en(round_en), .sat_en(sat_en), .a(a), .b(b),
    .out_valid(out_valid), .result(result), .ovf(ovf)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic chk(string tag, logic [W-1:0] got_r, logic [W-1:0] exp_r,
                     logic got_o, logic exp_o);
    n_run++;
    if (got_r !== exp_r || got_o !== exp_o) begin
      n_fail++;
      $display("FAIL %s: result %h ovf %b, expected %h ovf %b",
               tag, got_r, got_o, exp_r, exp_o);
    end
  endtask

  // drive at a falling edge, check at the next falling edge
  task automatic do_op(string tag, logic [1:0] o, logic sg, logic rn, logic st,
                       logic [W-1:0] x, logic [W-1:0] y,
                       logic [W-1:0] exp_r, logic exp_o);
    op = o; is_signed = sg; round_en = rn; sat_en = st; a = x; b = y;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    n_run++;
    if (out_valid !== 1'b1) begin
      n_fail++;
      $display("FAIL R1 %s: out_valid %b, expected 1", tag, out_valid);
    end
    chk(tag, result, exp_r, ovf, exp_o);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 reset", result, '0, ovf, 1'b0);
    n_run++;
    if (out_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset: out_valid %b, expected 0", out_valid);
    end
  endtask

  task automatic t_addsub;
    do_op("R3 add 1.5+2.25", 2'b00, 1, 0, 0, 32'h0001_8000, 32'h0002_4000, 32'h0003_C000, 0);
    do_op("R3 sub 1.0-2.5",  2'b01, 1, 0, 0, 32'h0001_0000, 32'h0002_8000, 32'hFFFE_8000, 0);
    do_op("R3 add round_en ignored", 2'b00, 1, 1, 0, 32'h0000_0001, 32'h0000_0001, 32'h0000_0002, 0);
  endtask

  task automatic t_mul;
    do_op("R4 mul 1.5*2",    2'b10, 1, 0, 0, 32'h0001_8000, 32'h0002_0000, 32'h0003_0000, 0);
    do_op("R4 mul -1.5*2",   2'b10, 1, 0, 0, 32'hFFFE_8000, 32'h0002_0000, 32'hFFFD_0000, 0);
    do_op("R4 mul .5*.5",    2'b10, 1, 0, 0, 32'h0000_8000, 32'h0000_8000, 32'h0000_4000, 0);
    do_op("R4 trunc +0.5lsb", 2'b10, 1, 0, 0, 32'h0000_0001, 32'h0000_8000, 32'h0000_0000, 0);
    do_op("R4 trunc -0.25lsb", 2'b10, 1, 0, 0, 32'hFFFF_FFFF, 32'h0000_4000, 32'hFFFF_FFFF, 0);
    do_op("R4 trunc -1.25lsb", 2'b10, 1, 0, 0, 32'hFFFF_FFFF, 32'h0001_4000, 32'hFFFF_FFFE, 0);
  endtask

  task automatic t_round;
    do_op("R5 round +0.5lsb",  2'b10, 1, 1, 0, 32'h0000_0001, 32'h0000_8000, 32'h0000_0001, 0);
    do_op("R5 round -0.5lsb",  2'b10, 1, 1, 0, 32'hFFFF_FFFF, 32'h0000_8000, 32'hFFFF_FFFF, 0);
    do_op("R5 round -0.25lsb", 2'b10, 1, 1, 0, 32'hFFFF_FFFF, 32'h0000_4000, 32'h0000_0000, 0);
    do_op("R5 round -1.25lsb", 2'b10, 1, 1, 0, 32'hFFFF_FFFF, 32'h0001_4000, 32'hFFFF_FFFF, 0);
    do_op("R5 round -1.5lsb",  2'b10, 1, 1, 0, 32'hFFFF_FFFF, 32'h0001_8000, 32'hFFFF_FFFE, 0);
  endtask

  task automatic t_overflow;
    do_op("R6 R8 signed add wrap", 2'b00, 1, 0, 0, 32'h7FFF_FFFF, 32'h0000_0001, 32'h8000_0000, 1);
    do_op("R6 signed mul 256*256", 2'b10, 1, 0, 0, 32'h0100_0000, 32'h0100_0000, 32'h0000_0000, 1);
    do_op("R6 R8 signed -32768*-1", 2'b10, 1, 0, 0, 32'h8000_0000, 32'hFFFF_0000, 32'h8000_0000, 1);
    do_op("R7 R8 unsigned 0-1",    2'b01, 0, 0, 0, 32'h0000_0000, 32'h0000_0001, 32'hFFFF_FFFF, 1);
    do_op("R7 unsigned add carry", 2'b00, 0, 0, 0, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 1);
    do_op("R7 unsigned mul 32768*2", 2'b10, 0, 0, 0, 32'h8000_0000, 32'h0002_0000, 32'h0000_0000, 1);
  endtask

  task automatic t_saturate;
    do_op("R9 signed max",  2'b00, 1, 0, 1, 32'h7FFF_FFFF, 32'h0000_0001, 32'h7FFF_FFFF, 1);
    do_op("R9 signed min",  2'b01, 1, 0, 1, 32'h8000_0000, 32'h0000_0001, 32'h8000_0000, 1);
    do_op("R9 signed mul -32768*-1", 2'b10, 1, 0, 1, 32'h8000_0000, 32'hFFFF_0000, 32'h7FFF_FFFF, 1);
    do_op("R9 unsigned zero", 2'b01, 0, 0, 1, 32'h0000_0000, 32'h0000_0001, 32'h0000_0000, 1);
    do_op("R9 unsigned max",  2'b10, 0, 0, 1, 32'h8000_0000, 32'h0002_0000, 32'hFFFF_FFFF, 1);
    do_op("R9 no ovf passes", 2'b00, 1, 0, 1, 32'h0001_0000, 32'h0001_0000, 32'h0002_0000, 0);
  endtask

  task automatic t_signsel;
    do_op("R10 signed -1*2",      2'b10, 1, 0, 0, 32'hFFFF_0000, 32'h0002_0000, 32'hFFFE_0000, 0);
    do_op("R10 unsigned 65535*2", 2'b10, 0, 0, 0, 32'hFFFF_0000, 32'h0002_0000, 32'hFFFE_0000, 1);
  endtask

  task automatic t_opcode;
    do_op("R2 op 11 multiplies", 2'b11, 1, 0, 0, 32'h0001_8000, 32'h0002_0000, 32'h0003_0000, 0);
    do_op("R2 op 01 subtracts",  2'b01, 0, 0, 0, 32'h0003_0000, 32'h0001_0000, 32'h0002_0000, 0);
  endtask

  task automatic t_hold;
    logic [W-1:0] keep;
    logic         keep_o;
    keep = result; keep_o = ovf;
    op = 2'b00; a = 32'h1234_5678; b = 32'h1111_1111; in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    n_run++;
    if (out_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 hold: out_valid %b, expected 0", out_valid);
    end
    chk("R1 hold", result, keep, ovf, keep_o);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_addsub();
    t_mul();
    t_round();
    t_overflow();
    t_saturate();
    t_signsel();
    t_opcode();
    t_hold();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule